// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller for an 8-bit successive-approximation analog-to-digital converter. It runs entirely from the instruction clock. A programmable divider turns that clock into a one-cycle conversion strobe (TAD). The sequencer then walks the SAR through a fixed 13-TAD conversion: one sample period, eight bit trials from the most significant bit down, and four settle periods. On every trial it presents a DAC code to the analog side and reads back a single comparator decision.

Software controls the block through write strobes. There is a write for the enable bit and one for the start/busy bit. There are writes for a channel select, a clock select and an analog pin mode. A sleep request cancels any conversion in progress and discards the channel and clock selections. Changes to the channel or the clock select made during a conversion are held back, each to its own boundary, so that the conversion under way finishes with consistent settings. If software clears the start/busy bit during a conversion, the conversion stops and the result keeps the bits resolved so far.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `busy` is 0, `result` is 0, `dac_code` is 0 and the applied channel is 00. The clock select is 11, the pin mode is 11 (channels 0, 1 and 2 analog) and the enable bit is 0.
- R2: A start write (`go_wr` with `go_din`=1) begins a conversion only when the enable bit is 1, no conversion is running and `sleep_req` is 0. Otherwise the write is ignored and `busy` stays as it was.
- R3: A conversion keeps `busy` high for exactly 13·D clock cycles. D is set by the clock select: 00 gives 32, 01 gives 16, 10 gives 8 and 11 gives 4.
- R4: TAD 0 is sampling. During TAD k (k = 1..8), `dac_code` equals the bits resolved so far with trial bit 8−k added. The trial bit is kept in `result` when `cmp_in` is 1 at the end of that TAD. `result` is cleared when a conversion starts.
- R5: When the 13th TAD ends, `busy` clears by itself and `result` holds the final code. This code is the largest value whose trial the comparator accepted.
- R6: A clear write (`go_wr` with `go_din`=0) during a conversion drops `busy` on the next cycle. `result` keeps the partial value it held and does not change afterwards.
- R7: A channel write while idle changes `chan_sel` on the next cycle. A channel write during a conversion is held and applied when that conversion completes or is cleared.
- R8: A clock-select write during a conversion does not change that conversion's length. It sets D for the next conversion started.
- R9: While `sleep_req` is 1, `busy` is 0, start writes are ignored, the channel is forced to 00 and the clock select to 11.
- R10: `samp_valid` is 1 only when the applied channel is analog under the pin mode. Pin mode 00 makes no channel analog, 01 makes channel 0 analog, 10 makes channels 0 and 1 analog, and 11 makes channels 0, 1 and 2 analog. Channel 11 is never analog.
- R11: `dac_code` and `result` never differ in more than one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable bit write strobe |
| en_din | input | 1 | Enable bit write value |
| go_wr | input | 1 | Start/busy bit write strobe |
| go_din | input | 1 | Start/busy write value (1 start, 0 abort) |
| chs_wr | input | 1 | Channel select write strobe |
| chs_din | input | 2 | Channel select value |
| cks_wr | input | 1 | Clock select write strobe |
| cks_din | input | 2 | Clock select value |
| pm_wr | input | 1 | Analog pin mode write strobe |
| pm_din | input | 2 | Analog pin mode value |
| sleep_req | input | 1 | Sleep request, level sensitive |
| cmp_in | input | 1 | Comparator decision, 1 keeps the trial bit |
| dac_code | output | RES_W | Trial code driven to the DAC |
| chan_sel | output | 2 | Applied analog channel |
| result | output | RES_W | Conversion result register |
| busy | output | 1 | Start/busy bit, high while converting |
| samp_valid | output | 1 | Applied channel is configured as analog |

## Verification
Each kind of internal error shows up at the ports in its own way. If the divider is reloaded wrongly, or the clock select is latched at the wrong moment, the length of the busy window changes by a whole multiple of D, so the error shows when busy falls, at most 416 cycles after the start. If the step counter or the bit-index mapping goes wrong, the final code differs from the bench's target. It also puts an unexpected pattern on `dac_code` one cycle after the first trial TAD begins. If the pending-channel slot or the sleep wipe fails, `chan_sel` takes a wrong value on the cycle right after the conversion ends or after sleep.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef logic [1:0] chan_t;

    typedef enum logic [1:0] {
        CKS_SLOW = 2'b00,
        CKS_MID  = 2'b01,
        CKS_FAST = 2'b10,
        CKS_OSC  = 2'b11
    } cks_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_CH0  = 2'b01,
        PM_CH01 = 2'b10,
        PM_ALL  = 2'b11
    } pinmode_e;

    typedef struct packed {
        logic start;
        logic abort;
        logic halt;
    } seq_ctl_t;

    // Divisor chosen by a clock-select code.
    function automatic int unsigned div_pick(input cks_e sel,
                                             input int unsigned d0,
                                             input int unsigned d1,
                                             input int unsigned d2,
                                             input int unsigned d3);
        case (sel)
            CKS_SLOW: return d0;
            CKS_MID:  return d1;
            CKS_FAST: return d2;
            default:  return d3;
        endcase
    endfunction

    // A channel is analog when its index is below the pin-mode code.
    function automatic logic chan_is_analog(input pinmode_e pm, input chan_t ch);
        return ch < chan_t'(pm);
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] reload_in,
    output logic             tad
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (load) begin
            cnt_q    <= reload_in;
            reload_q <= reload_in;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= reload_q;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tad = run && (cnt_q == '0);

    // R8: the divisor in use is frozen for the whole conversion
    a_r8_divisor_frozen: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(reload_q));

    // R3: strobes never occur on back-to-back cycles for divisors above one
    a_r3_tad_spacing: assert property (@(posedge clk) disable iff (rst)
        (tad && reload_q != '0) |=> !tad);

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import sar_seq_pkg::*;
#(
    parameter int RES_W  = 8,
    parameter int N_TADS = 13,
    parameter int STEP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_ctl_t         ctl,
    input  logic             tad,
    input  logic             cmp,
    output logic             busy,
    output logic             conv_done,
    output logic [RES_W-1:0] result,
    output logic [RES_W-1:0] dac_code
);
    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic [RES_W-1:0]  res_q;
    logic [RES_W-1:0]  trial_vec;
    logic              last_step;

    always_comb begin
        for (int i = 0; i < RES_W; i++) begin
            trial_vec[i] = busy_q && (step_q == STEP_W'(RES_W - i));
        end
    end

    assign last_step = (step_q == STEP_W'(N_TADS - 1));
    assign conv_done = busy_q && tad && last_step && !ctl.halt && !ctl.abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            res_q  <= '0;
        end else if (ctl.halt || ctl.abort) begin
            busy_q <= 1'b0;
            step_q <= '0;
        end else if (ctl.start) begin
            busy_q <= 1'b1;
            step_q <= '0;
            res_q  <= '0;
        end else if (busy_q && tad) begin
            if (cmp) res_q <= res_q | trial_vec;
            if (last_step) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign busy     = busy_q;
    assign result   = res_q;
    assign dac_code = res_q | trial_vec;

    // R11: at most one trial bit sits above the resolved bits
    a_r11_single_trial: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dac_code ^ result));

    // R6: an abort leaves the partial result untouched
    a_r6_abort_keeps: assert property (@(posedge clk) disable iff (rst)
        ctl.abort |=> ($stable(res_q) && !busy_q));

    // R9: sleep stops the sequencer
    a_r9_halt_idle: assert property (@(posedge clk) disable iff (rst)
        ctl.halt |=> !busy_q);

    // R5: completion clears busy by itself
    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !busy_q);

    // R4: the step counter stays inside the conversion
    a_r4_step_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (step_q < STEP_W'(N_TADS)));

endmodule

// File: rtl/adc_sel_regs.sv
module adc_sel_regs
    import sar_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     halt,
    input  logic     en_wr,
    input  logic     en_din,
    input  logic     chs_wr,
    input  chan_t    chs_din,
    input  logic     cks_wr,
    input  cks_e     cks_din,
    input  logic     pm_wr,
    input  pinmode_e pm_din,
    input  logic     busy,
    input  logic     conv_end,
    output logic     en_q,
    output chan_t    chan_q,
    output cks_e     cks_q,
    output pinmode_e pm_q
);
    chan_t pend_q;
    logic  pend_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            chan_q     <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            cks_q      <= CKS_OSC;
            pm_q       <= PM_ALL;
        end else begin
            if (en_wr) en_q <= en_din;
            if (pm_wr) pm_q <= pm_din;
            if (halt) begin
                chan_q     <= '0;
                pend_vld_q <= 1'b0;
                cks_q      <= CKS_OSC;
            end else begin
                if (cks_wr) cks_q <= cks_din;
                if (conv_end) begin
                    if (chs_wr)          chan_q <= chs_din;
                    else if (pend_vld_q) chan_q <= pend_q;
                    pend_vld_q <= 1'b0;
                end else if (chs_wr) begin
                    if (busy) begin
                        pend_q     <= chs_din;
                        pend_vld_q <= 1'b1;
                    end else begin
                        chan_q <= chs_din;
                    end
                end
            end
        end
    end

    // R7: the applied channel moves only while idle, at a conversion end, or on sleep
    a_r7_chan_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan_q) |-> ($past(!busy) || $past(conv_end) || $past(halt)));

    // R9: sleep restores the channel and clock-select defaults
    a_r9_sleep_defaults: assert property (@(posedge clk) disable iff (rst)
        halt |=> (chan_q == 2'b00 && cks_q == CKS_OSC));

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SETTLE_TADS = 4,
    parameter int DIV_SEL0    = 32,
    parameter int DIV_SEL1    = 16,
    parameter int DIV_SEL2    = 8,
    parameter int DIV_SEL3    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_din,
    input  logic             go_wr,
    input  logic             go_din,
    input  logic             chs_wr,
    input  logic [1:0]       chs_din,
    input  logic             cks_wr,
    input  logic [1:0]       cks_din,
    input  logic             pm_wr,
    input  logic [1:0]       pm_din,
    input  logic             sleep_req,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [1:0]       chan_sel,
    output logic [RES_W-1:0] result,
    output logic             busy,
    output logic             samp_valid
);
    localparam int N_TADS  = 1 + RES_W + SETTLE_TADS;
    localparam int STEP_W  = $clog2(N_TADS + 1);
    localparam int DIV_MAX = int'(max4(DIV_SEL0, DIV_SEL1, DIV_SEL2, DIV_SEL3));
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    seq_ctl_t         ctl;
    logic             en_q;
    chan_t            chan_q;
    cks_e             cks_q;
    pinmode_e         pm_q;
    logic             tad;
    logic             conv_done;
    logic [DIV_W-1:0] reload_val;

    assign ctl.halt  = sleep_req;
    assign ctl.start = go_wr && go_din && en_q && !busy && !sleep_req;
    assign ctl.abort = go_wr && !go_din && busy && !sleep_req;

    assign reload_val = DIV_W'(div_pick(cks_q, DIV_SEL0, DIV_SEL1, DIV_SEL2, DIV_SEL3) - 1);

    adc_sel_regs u_sel (
        .clk      (clk),
        .rst      (rst),
        .halt     (sleep_req),
        .en_wr    (en_wr),
        .en_din   (en_din),
        .chs_wr   (chs_wr),
        .chs_din  (chs_din),
        .cks_wr   (cks_wr),
        .cks_din  (cks_e'(cks_din)),
        .pm_wr    (pm_wr),
        .pm_din   (pinmode_e'(pm_din)),
        .busy     (busy),
        .conv_end (conv_done || ctl.abort),
        .en_q     (en_q),
        .chan_q   (chan_q),
        .cks_q    (cks_q),
        .pm_q     (pm_q)
    );

    adc_tad_gen #(.DIV_W(DIV_W)) u_tad (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.start),
        .run       (busy),
        .reload_in (reload_val),
        .tad       (tad)
    );

    adc_sar_core #(
        .RES_W  (RES_W),
        .N_TADS (N_TADS),
        .STEP_W (STEP_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .tad       (tad),
        .cmp       (cmp_in),
        .busy      (busy),
        .conv_done (conv_done),
        .result    (result),
        .dac_code  (dac_code)
    );

    assign chan_sel   = chan_q;
    assign samp_valid = chan_is_analog(pm_q, chan_q);

    // R2: a start write with the enable bit low is ignored
    a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (go_wr && go_din && !en_q && !busy) |=> !busy);

    // R2: an accepted start raises busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        ctl.start |=> busy);

    // R10: pin mode 00 never validates a channel
    a_r10_none_analog: assert property (@(posedge clk) disable iff (rst)
        (pm_q == PM_NONE) |-> !samp_valid);

endmodule

// File: tb/sar_adc_seq_tb_top.sv
`timescale 1ns/1ps
module sar_adc_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 0, en_din = 0, go_wr = 0, go_din = 0;
    logic       chs_wr = 0, cks_wr = 0, pm_wr = 0, sleep_req = 0;
    logic [1:0] chs_din = 0, cks_din = 0, pm_din = 0;
    logic       cmp_in;
    logic [7:0] dac_code, result, target = 8'h00;
    logic [1:0] chan_sel;
    logic       busy, samp_valid;
    int         checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (dac_code <= target);

    sar_adc_seq dut_i (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_din(en_din),
        .go_wr(go_wr), .go_din(go_din), .chs_wr(chs_wr), .chs_din(chs_din),
        .cks_wr(cks_wr), .cks_din(cks_din), .pm_wr(pm_wr), .pm_din(pm_din),
        .sleep_req(sleep_req), .cmp_in(cmp_in), .dac_code(dac_code),
        .chan_sel(chan_sel), .result(result), .busy(busy), .samp_valid(samp_valid)
    );

    function automatic int exp_div(input logic [1:0] c);
        case (c)
            2'b00: return 32;
            2'b01: return 16;
            2'b10: return 8;
            default: return 4;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wr_en(input logic v);
        en_wr = 1; en_din = v; @(negedge clk); en_wr = 0;
    endtask
    task automatic wr_chs(input logic [1:0] v);
        chs_wr = 1; chs_din = v; @(negedge clk); chs_wr = 0;
    endtask
    task automatic wr_cks(input logic [1:0] v);
        cks_wr = 1; cks_din = v; @(negedge clk); cks_wr = 0;
    endtask
    task automatic wr_pm(input logic [1:0] v);
        pm_wr = 1; pm_din = v; @(negedge clk); pm_wr = 0;
    endtask
    task automatic wr_go(input logic v);
        go_wr = 1; go_din = v; @(negedge clk); go_wr = 0;
    endtask

    // Start and count negedges with busy high; returns at the first idle negedge.
    task automatic run_conv(output int n);
        wr_go(1'b1);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        logic [1:0] c;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 result", result, 0);
        chk("R1 dac_code", dac_code, 0);
        chk("R1 chan_sel", chan_sel, 0);

        // R10 reset pin mode makes channel 2 analog, channel 3 never
        wr_chs(2'd2); chk("R10 reset mode ch2", samp_valid, 1);
        wr_chs(2'd3); chk("R10 ch3 never", samp_valid, 0);
        wr_pm(2'b01); chk("R10 mode01 ch3", samp_valid, 0);
        wr_chs(2'd0); chk("R10 mode01 ch0", samp_valid, 1);
        wr_chs(2'd1); chk("R10 mode01 ch1", samp_valid, 0);
        wr_pm(2'b10); chk("R10 mode10 ch1", samp_valid, 1);
        wr_pm(2'b00); chk("R10 mode00 ch1", samp_valid, 0);
        wr_pm(2'b11);

        // R2 start ignored with enable low
        target = 8'h55;
        wr_go(1'b1);
        chk("R2 disabled start", busy, 0);
        @(negedge clk);
        chk("R2 disabled start later", busy, 0);

        // R1 default clock select gives D=4; R3 R5 full conversion
        wr_en(1'b1);
        target = 8'hA6;
        run_conv(n);
        chk("R3 default divisor length", n, 13 * 4);
        chk("R5 result", result, 8'hA6);
        chk("R5 busy cleared", busy, 0);

        // R4 trial pattern with D=8
        wr_cks(2'b10);
        target = 8'h3C;
        wr_go(1'b1);
        repeat (8) @(negedge clk);
        chk("R4 first trial dac", dac_code, 8'h80);
        chk("R4 first trial result", result, 8'h00);
        repeat (8) @(negedge clk);
        chk("R4 second trial dac", dac_code, 8'h40);
        while (busy) @(negedge clk);
        chk("R4 final code", result, 8'h3C);

        // R5 corner targets
        target = 8'hFF; run_conv(n); chk("R5 target ff", result, 8'hFF);
        target = 8'h00; run_conv(n); chk("R5 target 00", result, 8'h00);

        // R3 R5 random divisors and targets
        for (int i = 0; i < 8; i++) begin
            c = 2'($urandom % 4);
            target = 8'($urandom);
            wr_cks(c);
            run_conv(n);
            chk("R3 random length", n, 13 * exp_div(c));
            chk("R5 random result", result, int'(target));
        end

        // R8 clock select change mid-conversion
        wr_cks(2'b10);
        target = 8'h11;
        wr_go(1'b1);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            cks_wr = (n == 3); cks_din = 2'b00;
            @(negedge clk);
        end
        cks_wr = 0;
        chk("R8 length held", n, 13 * 8);
        run_conv(n);
        chk("R8 next conversion uses new select", n, 13 * 32);

        // R7 channel change while busy
        wr_cks(2'b11);
        wr_chs(2'd1);
        chk("R7 idle write", chan_sel, 1);
        wr_go(1'b1);
        wr_chs(2'd2);
        chk("R7 held during conversion", chan_sel, 1);
        while (busy) @(negedge clk);
        chk("R7 applied at completion", chan_sel, 2);

        // R6 abort: D=4, abort on negedge 20 -> three bits resolved
        target = 8'hB7;
        wr_go(1'b1);
        repeat (19) @(negedge clk);
        wr_go(1'b0);
        chk("R6 busy dropped", busy, 0);
        chk("R6 partial result", result, 8'hA0);
        repeat (10) @(negedge clk);
        chk("R6 partial result held", result, 8'hA0);

        // R9 sleep mid-conversion
        wr_cks(2'b01);
        wr_chs(2'd2);
        wr_go(1'b1);
        repeat (5) @(negedge clk);
        sleep_req = 1;
        @(negedge clk);
        chk("R9 busy cleared", busy, 0);
        chk("R9 channel wiped", chan_sel, 0);
        wr_go(1'b1);
        chk("R9 start ignored in sleep", busy, 0);
        sleep_req = 0;
        @(negedge clk);
        target = 8'h42;
        run_conv(n);
        chk("R9 clock select back to 11", n, 13 * 4);
        chk("R9 conversion after wake", result, 8'h42);

        summary();
        $finish;
    end
endmodule